// File: doc/BRIEF.md
# Seeded Fibonacci Term Generator

This block walks through a Fibonacci-style sequence. Each new term is the wrapped sum of the two terms before it. Two registers hold the state: the current term and the term after it. An adder sums the two registers.

A load strobe seeds both registers in one clock edge from two external start values. The usual seeds are 0 and 1, but any pair is accepted. On every clock edge without load, the pair steps forward by one term.

Two taps are visible at the outputs:
- The current-term register, which runs f0, f1, f2, … after seeding.
- The adder result, which runs two terms ahead: f2, f3, f4, ….

The block has no reset. Its state is meaningful only after the first load.

Top module: `fib_gen`

## Requirements
- R1: On a clock edge with `load` high, the current-term register takes `seedFirst` and the next-term register takes `seedSecond`. After that edge, `curTerm` equals `seedFirst` and `sumTerm` equals `seedFirst + seedSecond` (wrapped).
- R2: Load wins over stepping. While `load` stays high, every edge recaptures the seeds, so `curTerm` and `sumTerm` keep showing the seed values and do not step.
- R3: On a clock edge with `load` low, the current-term register takes the old next-term value, and the next-term register takes the old sum.
- R4: After seeding with f0 and f1 and then k steps, `curTerm` shows f(k) and `sumTerm` shows f(k+2).
- R5: All arithmetic wraps modulo 2^WIDTH. There is no carry-out or overflow indication.
- R6: The term width is the parameter `WIDTH` (default 4). A 16-bit build follows the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| load | input | 1 | Seed strobe; loads both registers when high |
| seedFirst | input | WIDTH | Start value for the current-term register (f0) |
| seedSecond | input | WIDTH | Start value for the next-term register (f1) |
| curTerm | output | WIDTH | Current-term register (f0, f1, …) |
| sumTerm | output | WIDTH | Adder output, two terms ahead (f2, f3, …) |

## Verification
The bench builds two instances side by side, sharing the load strobe: one with `WIDTH` = 4 and one with `WIDTH` = 16. At 4 bits, the standard 0/1 seed overflows after a handful of steps, so wraparound is exercised early and repeatedly. The 16-bit copy runs long enough to wrap past 65535, which confirms that the same rules hold at a wider width. Between the runs, the bench re-seeds with arbitrary pairs and holds load high, to exercise load priority.

// File: rtl/fib_pkg.sv
package fib_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic takeSeed;  // parallel load of both registers
    logic step;      // advance one term
  } fibCtl_t;
endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
  import fib_pkg::*;
(
  input  logic    load,
  output fibCtl_t ctl
);
  // Load has priority; otherwise the pair always steps.
  always_comb begin
    ctl.takeSeed = load;
    ctl.step     = ~load;
  end
endmodule

// File: rtl/fib_dp.sv
module fib_dp
  import fib_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  fibCtl_t          ctl,
  input  logic [WIDTH-1:0] seedFirst,
  input  logic [WIDTH-1:0] seedSecond,
  output logic [WIDTH-1:0] curTerm,
  output logic [WIDTH-1:0] sumTerm
);
  logic [WIDTH-1:0] curReg;
  logic [WIDTH-1:0] nextReg;
  logic [WIDTH-1:0] addOut;
  logic [WIDTH-1:0] curD;
  logic [WIDTH-1:0] nextD;

  // Natural modulo-2^WIDTH add; carry dropped
  assign addOut = curReg + nextReg;

  // Input multiplexers select the seed or the stepped value
  always_comb begin
    curD  = curReg;
    nextD = nextReg;
    if (ctl.takeSeed) begin
      curD  = seedFirst;
      nextD = seedSecond;
    end else if (ctl.step) begin
      curD  = nextReg;
      nextD = addOut;
    end
  end

  always_ff @(posedge clk) begin
    curReg  <= curD;
    nextReg <= nextD;
  end

  assign curTerm = curReg;
  assign sumTerm = addOut;
endmodule

// File: rtl/fib_gen.sv
module fib_gen
  import fib_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             load,
  input  logic [WIDTH-1:0] seedFirst,
  input  logic [WIDTH-1:0] seedSecond,
  output logic [WIDTH-1:0] curTerm,
  output logic [WIDTH-1:0] sumTerm
);
  fibCtl_t ctl;

  fib_ctrl u_ctrl (
    .load (load),
    .ctl  (ctl)
  );

  fib_dp #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .ctl        (ctl),
    .seedFirst  (seedFirst),
    .seedSecond (seedSecond),
    .curTerm    (curTerm),
    .sumTerm    (sumTerm)
  );
endmodule

// File: rtl/fib_gen_chk.sv
module fib_gen_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             load,
  input logic [WIDTH-1:0] seedFirst,
  input logic [WIDTH-1:0] seedSecond,
  input logic [WIDTH-1:0] curTerm,
  input logic [WIDTH-1:0] sumTerm
);
  // No reset exists: checks are enabled only once a seed has been loaded.
  logic seeded = 1'b0;
  always_ff @(posedge clk) if (load) seeded <= 1'b1;

  // R1: a load edge presents the seeds on both taps
  p_load_seed_r1: assert property (@(posedge clk) disable iff (!seeded)
    load |=> (curTerm == $past(seedFirst)) &&
             (sumTerm == WIDTH'($past(seedFirst) + $past(seedSecond))));

  // R2: load held with stable seeds leaves the taps frozen
  p_hold_load_r2: assert property (@(posedge clk) disable iff (!seeded)
    (load && $past(load) && seedFirst == $past(seedFirst) &&
     seedSecond == $past(seedSecond)) |=> $stable(curTerm) && $stable(sumTerm));

  // R3: a step moves the old next term (sum - cur) into the current tap
  p_step_cur_r3: assert property (@(posedge clk) disable iff (!seeded)
    !load |=> curTerm == WIDTH'($past(sumTerm) - $past(curTerm)));

  // R4, R5: the sum tap advances to old next + old sum, wrapped
  p_sum_ahead_r4: assert property (@(posedge clk) disable iff (!seeded)
    !load |=> sumTerm == WIDTH'(2 * $past(sumTerm) - $past(curTerm)));
endmodule

bind fib_gen fib_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .load       (load),
  .seedFirst  (seedFirst),
  .seedSecond (seedSecond),
  .curTerm    (curTerm),
  .sumTerm    (sumTerm)
);

// File: tb/test_fib_gen.sv
module test_fib_gen;
  logic        clk = 1'b0;
  logic        load = 1'b0;
  logic [15:0] seedA = '0;
  logic [15:0] seedB = '0;
  logic [3:0]  cur4, sum4;
  logic [15:0] cur16, sum16;

  always #5 clk = ~clk;  // 100 MHz

  fib_gen #(.WIDTH(4)) i_fib_gen (
    .clk(clk), .load(load), .seedFirst(seedA[3:0]), .seedSecond(seedB[3:0]),
    .curTerm(cur4), .sumTerm(sum4)
  );
  fib_gen #(.WIDTH(16)) i_fib_gen_w16 (
    .clk(clk), .load(load), .seedFirst(seedA), .seedSecond(seedB),
    .curTerm(cur16), .sumTerm(sum16)
  );

  typedef struct {
    logic [3:0]  c4, s4;
    logic [15:0] c16, s16;
    string       tag;
  } item_t;

  item_t scoreQ[$];
  int nRun = 0, nFail = 0;
  logic [3:0]  m4c, m4n;
  logic [15:0] m16c, m16n;

  task automatic chk(string tag, string what, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: one clock per call; pushes the result expected after the edge
  task automatic drive(logic ld, logic [15:0] a, logic [15:0] b, string tag);
    item_t it;
    @(negedge clk);
    load = ld; seedA = a; seedB = b;
    if (ld) begin
      m4c = a[3:0]; m4n = b[3:0]; m16c = a; m16n = b;
    end else begin
      logic [3:0]  t4;
      logic [15:0] t16;
      t4 = 4'(m4c + m4n);    m4c = m4n;   m4n = t4;
      t16 = 16'(m16c + m16n); m16c = m16n; m16n = t16;
    end
    it.c4 = m4c; it.s4 = 4'(m4c + m4n);
    it.c16 = m16c; it.s16 = 16'(m16c + m16n);
    it.tag = tag;
    scoreQ.push_back(it);
  endtask

  // Monitor: samples mid-high phase, after the edge has settled
  initial forever begin
    @(posedge clk); #2;
    if (scoreQ.size() > 0) begin
      item_t e;
      e = scoreQ.pop_front();
      chk(e.tag, "cur4",  int'(cur4),  int'(e.c4));
      chk(e.tag, "sum4",  int'(sum4),  int'(e.s4));
      chk({e.tag, "/R6"}, "cur16", int'(cur16), int'(e.c16));
      chk({e.tag, "/R6"}, "sum16", int'(sum16), int'(e.s16));
    end
  end

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R1: standard seed 0,1; then R3/R4 stepping with R5 wrap at 4 bits
    drive(1'b1, 16'd0, 16'd1, "R1");
    for (int i = 0; i < 20; i++) drive(1'b0, 16'd0, 16'd0, "R4_R5");
    // R2: load held high with new seeds, taps stay on seeds
    for (int i = 0; i < 3; i++) drive(1'b1, 16'd5, 16'd9, "R2");
    // R3: arbitrary seed pair, short run
    drive(1'b1, 16'd3, 16'd7, "R1");
    for (int i = 0; i < 15; i++) drive(1'b0, 16'd0, 16'd0, "R3");
    // R5/R6: long 16-bit run crossing 65535
    drive(1'b1, 16'd0, 16'd1, "R1");
    for (int i = 0; i < 30; i++) drive(1'b0, 16'd0, 16'd0, "R5");
    // R1: large seeds whose sum wraps immediately
    drive(1'b1, 16'hFFF0, 16'h0015, "R1_R5");
    drive(1'b0, 16'd0, 16'd0, "R3");
    @(negedge clk); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule